// File: doc/BRIEF.md
# Hourly Chime and Tone Generator

This block listens to the BCD minute and second digits of a running clock and sounds a countdown toward the top of each hour. In minute 59 it produces five one-second beeps, one on each even second from 50 to 58. The first four use the low tone. The last one uses the high tone. The block also rings while an external alarm-match flag is high. The ring alternates between the two tones every half second.

All sounds share one square-wave speaker pin, and an enable input can silence that pin. Three status flags report which sound is currently selected. Both tones come from a one-cycle reference strobe that arrives at 1 kHz:
- The high tone toggles on every strobe.
- The low tone toggles on every second strobe, so it runs at half the high-tone frequency.

Time counting and display are handled elsewhere. All outputs are registered, so they respond one clock after the inputs change.

Top module: `chime_tone_gen`

## Requirements
- R1: During reset, and on the first edge after it, the outputs `spk`, `beep_low`, `beep_high` and `ring_on` are all low. The reference-strobe count restarts at zero.
- R2: One clock after the digits show minute 5,9 and second tens 5 with second ones 0, 2, 4 or 6, `beep_low` is high. In that case `spk` equals bit 1 of the reference-strobe count.
- R3: One clock after the digits show 59:58, `beep_high` is high and `spk` equals bit 0 of the reference-strobe count.
- R4: On odd seconds of 59:5x, and at any time outside 59:50 to 59:58, both beep flags are low.
- R5: The reference-strobe count advances by one on each clock where `tone_tick` is high and holds otherwise. The high tone is bit 0 of this count and the low tone is bit 1.
- R6: While `alarm_hit` is high and no beep is due, `ring_on` is high and the tone alternates, starting with the high tone:
  - it uses the high tone for the first HALF_TICKS strobes counted since the ring started;
  - it then uses the low tone for the next HALF_TICKS strobes;
  - it keeps alternating in this way.
  A drop of `alarm_hit` restarts the pattern on the high tone.
- R7: When a beep is due while `alarm_hit` is high, the beep is played and `ring_on` is low.
- R8: One clock after `spk_en` is low, `spk` is low. The status flags are unaffected.
- R9: At most one of `beep_low`, `beep_high` and `ring_on` is high.
- R10: When no status flag is high, `spk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_tick | input | 1 | One-cycle 1 kHz reference strobe |
| min_tens | input | 4 | BCD tens digit of minutes |
| min_ones | input | 4 | BCD ones digit of minutes |
| sec_tens | input | 4 | BCD tens digit of seconds |
| sec_ones | input | 4 | BCD ones digit of seconds |
| alarm_hit | input | 1 | Alarm time matches the current time |
| spk_en | input | 1 | Speaker enable; low forces silence |
| spk | output | 1 | Square-wave speaker drive |
| beep_low | output | 1 | Low-pitch countdown beep active |
| beep_high | output | 1 | Final high-pitch beep active |
| ring_on | output | 1 | Alarm ring active |

## Verification
If the tone divider state is wrong, the speaker level is wrong one clock after the next strobe. The bench therefore compares `spk` against its own strobe count after every strobe in every scenario. A half-second counter that is wrong shows up as the ring switching tones one strobe early or late. For that reason the alarm scenario checks every strobe across more than two alternation periods, including both boundaries. Schedule decode faults appear as a wrong flag on the very next clock, so each second from 59:48 to 59:59 and a few times outside the window are visited.

// File: rtl/chime_pkg.sv
package chime_pkg;
  typedef enum logic [1:0] {
    SND_NONE = 2'd0,
    SND_LOW  = 2'd1,
    SND_HIGH = 2'd2,
    SND_RING = 2'd3
  } sound_t;
endpackage

// File: rtl/chime_tone_div.sv
module chime_tone_div #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tone_tick,
  output logic tone_hi,
  output logic tone_lo
);
  localparam logic [DIV_W-1:0] STEP = DIV_W'(1);

  logic [DIV_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else if (tone_tick) phase_q <= phase_q + STEP;
  end

  assign tone_hi = phase_q[0];
  assign tone_lo = phase_q[1];

  AST_TONE_STEP: assert property (@(posedge clk) disable iff (rst)
    tone_tick |=> phase_q == $past(phase_q) + STEP); // R5
  AST_TONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tone_tick |=> $stable(phase_q)); // R5
endmodule

// File: rtl/chime_schedule.sv
module chime_schedule
  import chime_pkg::*;
#(
  parameter int          DIG_W     = 4,
  parameter logic [3:0]  MIN_TENS  = 4'd5,
  parameter logic [3:0]  MIN_ONES  = 4'd9,
  parameter logic [3:0]  SEC_TENS  = 4'd5,
  parameter logic [3:0]  LAST_ONES = 4'd8
) (
  input  logic [DIG_W-1:0] min_tens,
  input  logic [DIG_W-1:0] min_ones,
  input  logic [DIG_W-1:0] sec_tens,
  input  logic [DIG_W-1:0] sec_ones,
  input  logic             alarm_hit,
  output sound_t           sound
);
  logic in_window;
  logic beep_due;

  always_comb begin
    in_window = (min_tens == DIG_W'(MIN_TENS)) && (min_ones == DIG_W'(MIN_ONES))
             && (sec_tens == DIG_W'(SEC_TENS));
    beep_due  = in_window && !sec_ones[0] && (sec_ones <= DIG_W'(LAST_ONES));
    if (beep_due)
      sound = (sec_ones == DIG_W'(LAST_ONES)) ? SND_HIGH : SND_LOW;
    else if (alarm_hit)
      sound = SND_RING;
    else
      sound = SND_NONE;
  end
endmodule

// File: rtl/chime_ring_alt.sv
module chime_ring_alt #(
  parameter int HALF_TICKS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic tone_tick,
  input  logic ring_active,
  output logic use_low
);
  localparam int CNT_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sel_q;

  always_ff @(posedge clk) begin
    if (rst || !ring_active) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else if (tone_tick) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        sel_q <= ~sel_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign use_low = sel_q;

  AST_RING_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tone_tick && ring_active) |=> $stable(sel_q)); // R6
  AST_RING_RESTART: assert property (@(posedge clk) disable iff (rst)
    !ring_active |=> !sel_q); // R6
endmodule

// File: rtl/chime_tone_gen.sv
module chime_tone_gen
  import chime_pkg::*;
#(
  parameter int HALF_TICKS = 500,
  parameter int DIG_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tone_tick,
  input  logic [DIG_W-1:0] min_tens,
  input  logic [DIG_W-1:0] min_ones,
  input  logic [DIG_W-1:0] sec_tens,
  input  logic [DIG_W-1:0] sec_ones,
  input  logic             alarm_hit,
  input  logic             spk_en,
  output logic             spk,
  output logic             beep_low,
  output logic             beep_high,
  output logic             ring_on
);
  localparam int DIV_W = 2;

  sound_t sound;
  logic   tone_hi, tone_lo, ring_low, tone_now;

  chime_tone_div #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst(rst), .tone_tick(tone_tick),
    .tone_hi(tone_hi), .tone_lo(tone_lo)
  );

  chime_schedule #(.DIG_W(DIG_W)) i_sched (
    .min_tens(min_tens), .min_ones(min_ones),
    .sec_tens(sec_tens), .sec_ones(sec_ones),
    .alarm_hit(alarm_hit), .sound(sound)
  );

  chime_ring_alt #(.HALF_TICKS(HALF_TICKS)) i_ring (
    .clk(clk), .rst(rst), .tone_tick(tone_tick),
    .ring_active(sound == SND_RING), .use_low(ring_low)
  );

  always_comb begin
    case (sound)
      SND_LOW:  tone_now = tone_lo;
      SND_HIGH: tone_now = tone_hi;
      SND_RING: tone_now = ring_low ? tone_lo : tone_hi;
      default:  tone_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spk       <= 1'b0;
      beep_low  <= 1'b0;
      beep_high <= 1'b0;
      ring_on   <= 1'b0;
    end else begin
      spk       <= spk_en & tone_now;
      beep_low  <= (sound == SND_LOW);
      beep_high <= (sound == SND_HIGH);
      ring_on   <= (sound == SND_RING);
    end
  end

  AST_ONE_SOUND: assert property (@(posedge clk) disable iff (rst)
    $onehot0({beep_low, beep_high, ring_on})); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(beep_low || beep_high || ring_on) |-> !spk); // R10
  AST_MUTE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(spk_en)) |-> !spk); // R8
  AST_ODD_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sec_ones[0])) |-> !(beep_low || beep_high)); // R4
  AST_LAST_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(min_tens == 4'd5 && min_ones == 4'd9
      && sec_tens == 4'd5 && sec_ones == 4'd8)) |-> beep_high); // R3
endmodule

// File: tb/test_chime_tone_gen.sv
module test_chime_tone_gen;
  localparam int HALF = 500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tone_tick = 1'b0;
  logic [3:0] mt = 4'd0, mo = 4'd0, st = 4'd0, so = 4'd0;
  logic al = 1'b0, en = 1'b1;
  logic spk, beep_low, beep_high, ring_on;

  int total = 0, bad = 0;
  int n = 0;   // reference strobes since reset
  int k = 0;   // strobes counted during the current ring
  bit done = 0;

  always #10 clk = ~clk;

  chime_tone_gen #(.HALF_TICKS(HALF)) i_chime_tone_gen (
    .clk(clk), .rst(rst), .tone_tick(tone_tick),
    .min_tens(mt), .min_ones(mo), .sec_tens(st), .sec_ones(so),
    .alarm_hit(al), .spk_en(en),
    .spk(spk), .beep_low(beep_low), .beep_high(beep_high), .ring_on(ring_on)
  );

  function automatic int exp_snd();
    if (mt == 5 && mo == 9 && st == 5 && so[0] == 1'b0 && so <= 8)
      return (so == 8) ? 2 : 1;
    if (al) return 3;
    return 0;
  endfunction

  function automatic logic exp_spk();
    int s;
    logic hi, lo;
    s  = exp_snd();
    hi = logic'(n & 1);
    lo = logic'((n >> 1) & 1);
    if (!en) return 1'b0;
    case (s)
      1: return lo;
      2: return hi;
      3: return (((k / HALF) % 2) == 1) ? lo : hi;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b (time %02d%0d:%0d%0d n=%0d k=%0d)",
               tag, got, exp, mt, mo, st, so, n, k);
    end
  endtask

  task automatic check_all(input string tag);
    int s;
    s = exp_snd();
    check({tag, " beep_low"},  beep_low,  s == 1);
    check({tag, " beep_high"}, beep_high, s == 2);
    check({tag, " ring_on"},   ring_on,   s == 3);
    check({tag, " spk"},       spk,       exp_spk());
    check("R9 onehot", $onehot0({beep_low, beep_high, ring_on}), 1'b1);
    if (!(beep_low || beep_high || ring_on)) check("R10 idle quiet", spk, 1'b0);
  endtask

  task automatic step(input string tag);
    @(posedge clk); #1;
    check_all(tag);
    if (exp_snd() != 3) k = 0;
  endtask

  task automatic tick();
    tone_tick = 1'b1;
    @(posedge clk); #1;
    tone_tick = 1'b0;
    n++;
    if (exp_snd() == 3) k++; else k = 0;
  endtask

  task automatic set_time(input int m, input int s);
    mt = 4'(m / 10); mo = 4'(m % 10); st = 4'(s / 10); so = 4'(s % 10);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 spk", spk, 1'b0);
    check("R1 beep_low", beep_low, 1'b0);
    check("R1 beep_high", beep_high, 1'b0);
    check("R1 ring_on", ring_on, 1'b0);
    rst = 1'b0;
    n = 0; k = 0;
    step("R1 first");
  endtask

  task automatic t_tones();
    set_time(59, 50);
    for (int i = 0; i < 6; i++) begin step("R2 R5 low tone"); tick(); end
    set_time(59, 58);
    for (int i = 0; i < 6; i++) begin step("R3 R5 high tone"); tick(); end
  endtask

  task automatic t_schedule();
    for (int s = 48; s < 60; s++) begin
      set_time(59, s);
      step((s % 2 == 1 || s < 50) ? "R4 schedule" : "R2 R3 schedule");
      tick();
      step("R4 R2 schedule after tick");
    end
    set_time(58, 50); step("R4 other minute"); tick(); step("R4 other minute");
    set_time(0, 0);   step("R4 midnight");
    set_time(49, 58); step("R4 minute 49");
  endtask

  task automatic t_alarm();
    set_time(12, 0);
    al = 1'b1;
    step("R6 ring start");
    for (int i = 0; i < 2 * HALF + 20; i++) begin
      tick();
      step("R6 ring alternation");
    end
    al = 1'b0; step("R6 ring off");
    al = 1'b1; step("R6 ring restart high");
    tick(); step("R6 ring restart high");
  endtask

  task automatic t_priority();
    al = 1'b1;
    set_time(59, 54); step("R7 chime over alarm"); tick(); step("R7 chime over alarm");
    set_time(59, 58); step("R7 last beep over alarm");
    set_time(59, 55); step("R7 alarm in odd second");
    al = 1'b0;
  endtask

  task automatic t_mute();
    en = 1'b0;
    set_time(59, 52);
    for (int i = 0; i < 4; i++) begin step("R8 muted beep"); tick(); end
    al = 1'b1; set_time(10, 0);
    for (int i = 0; i < 4; i++) begin step("R8 muted ring"); tick(); end
    al = 1'b0;
    en = 1'b1;
    set_time(59, 58); step("R8 unmuted");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tones();
    t_schedule();
    t_alarm();
    t_priority();
    t_mute();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule